// File: doc/BRIEF.md
# Framed Synchronous Serial Port with Enable

This block is a full-duplex synchronous serial port that moves 16-bit words framed by one-bit frame-sync pulses. It derives its own serial clock from the master clock. The divide ratio is the product of a prescale divider and a bit-rate divider, both supplied as inputs. On the transmit side it drives a data line and a frame-sync line, each with its own pad output enable. On the receive side it samples a data line and a frame-sync line on the falling serial-clock edge.

Host logic hands over a transmit word with a valid/ready handshake and receives each incoming word with a one-cycle valid strobe. An asynchronous port enable gates the whole port. While the port is off, the serial clock stops, both transmit pads are released and the receive pins are ignored. When the port comes back on, the stored transmit and receive words are retained, but every timing counter and transfer in flight restarts from its reset value.

Top module: `fsport`

## Requirements
- R1: With effective divider values M and S (R7), the serial clock period P is M*S master-clock cycles, raised to 2 when the product is 1. The serial clock is high for the first floor(P/2) cycles of each period.
- R2: While the port is enabled, `txd_out` and `txfs_out` change only in the master-clock edge on which `ser_clk` rises.
- R3: A transmitted word is 16 bits, MSB first. `txfs_out` is high for exactly one serial-clock period, the period just before the MSB. `txd_oe` is high for the 16 bit periods that follow.
- R4: `txd_oe` is low whenever no data bit is being sent, including the frame-sync period and the idle time between words.
- R5: `rxfs_in` and `rxd_in` are sampled on falling edges of `ser_clk`. After `rxfs_in` is seen high, the next 16 samples form a word, MSB first. `rx_data` then shows that word, and `rx_valid` is high for one master-clock cycle in the cycle after the LSB sample.
- R6: `tx_ready` is high only while the port is enabled and no word is held or being sent. A word is taken on a clock edge where `tx_valid` and `tx_ready` are both high, and `tx_ready` stays low from the next cycle until the word has been sent.
- R7: A divider input of zero acts as one, so the serial clock never stalls because of a divider setting.
- R8: `port_en` passes through a two-flop synchronizer. While the synchronized enable is low, `ser_clk` is held low, `txd_oe`, `txfs_oe` and `tx_ready` are low, and `rxd_in`/`rxfs_in` are ignored, so `rx_valid` never rises.
- R9: When the enable returns high, `rx_data` and the held transmit word keep their values, any partly sent or received word is dropped, and the serial clock restarts with a rising edge.
- R10: While `rst_n` is low, `rx_data` is zero and all outputs are low. The reset release is synchronized to the master clock.
- R11: A frame sync seen on the same falling edge as the LSB of a word starts the next word at once, so back-to-back words need no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Asynchronous port enable |
| pre_div | input | DIV_W | Prescale divider (0 acts as 1) |
| bit_div | input | DIV_W | Bit-rate divider (0 acts as 1) |
| tx_data | input | WORD_W | Word to transmit |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Port can take a transmit word |
| rx_data | output | WORD_W | Last received word |
| rx_valid | output | 1 | One-cycle strobe for a new received word |
| ser_clk | output | 1 | Generated serial clock |
| txd_out | output | 1 | Serial data out |
| txd_oe | output | 1 | Pad enable for serial data out |
| txfs_out | output | 1 | Transmit frame sync |
| txfs_oe | output | 1 | Pad enable for transmit frame sync |
| rxd_in | input | 1 | Serial data in |
| rxfs_in | input | 1 | Receive frame sync |

## Verification
Two situations are hard to reach from the ports. The first is a frame sync that lands on the LSB slot of the word before it. A plain loopback never produces this, so the bench takes over the receive pins and drives them itself, one serial-clock rising edge at a time, with the sync placed on the last bit period. The second is a disable in the middle of a word. The bench starts an untracked loopback transfer, drops the enable partway through, drives noise on the receive pins while the port is off, and then shows that the old received word survived and the new transfer starts clean.

// File: rtl/fsp_pkg.sv
`timescale 1ns/1ps
package fsp_pkg;
  typedef enum logic [1:0] {TX_IDLE, TX_WAIT, TX_SYNC, TX_DATA} fsp_tx_st_e;
  typedef enum logic {RX_HUNT, RX_BITS} fsp_rx_st_e;
endpackage

// File: rtl/fsp_sync2.sv
`timescale 1ns/1ps
module fsp_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/fsp_clkgen.sv
`timescale 1ns/1ps
module fsp_clkgen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] pre_div,
  input  logic [DIV_W-1:0] bit_div,
  output logic             ser_clk,
  output logic             rise,
  output logic             fall
);
  localparam int PW = 2 * DIV_W;

  logic [DIV_W-1:0] m_eff, s_eff;
  logic [PW-1:0]    prod, per, half, last;
  logic [PW-1:0]    ph_q, ph_nxt;
  logic             sclk_q, sclk_nxt;

  // zero settings act as one; a product of one is raised to two
  assign m_eff = (pre_div == '0) ? DIV_W'(1) : pre_div;
  assign s_eff = (bit_div == '0) ? DIV_W'(1) : bit_div;
  assign prod  = PW'(m_eff) * PW'(s_eff);
  assign per   = (prod < PW'(2)) ? PW'(2) : prod;
  assign half  = per >> 1;
  assign last  = per - PW'(1);

  always_comb begin
    if (!en)
      ph_nxt = last;
    else if (ph_q >= last)
      ph_nxt = '0;
    else
      ph_nxt = ph_q + PW'(1);
    sclk_nxt = en && (ph_nxt < half);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      sclk_q <= 1'b0;
    end else begin
      ph_q   <= ph_nxt;
      sclk_q <= sclk_nxt;
    end
  end

  assign rise    = sclk_nxt && !sclk_q;
  assign fall    = en && !sclk_nxt && sclk_q;
  assign ser_clk = sclk_q;
endmodule

// File: rtl/fsp_tx.sv
`timescale 1ns/1ps
module fsp_tx
  import fsp_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rise,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              bit_out,
  output logic              fs_out,
  output logic              driving
);
  localparam int CW = $clog2(WORD_W + 1);

  fsp_tx_st_e        st_q, st_n;
  logic [WORD_W-1:0] hold_q, hold_n, sh_q, sh_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic              bit_q, bit_n, fs_q, fs_n;

  assign tx_ready = en && (st_q == TX_IDLE);

  always_comb begin
    st_n   = st_q;
    hold_n = hold_q;
    sh_n   = sh_q;
    cnt_n  = cnt_q;
    bit_n  = bit_q;
    fs_n   = fs_q;
    if (!en) begin
      // timing state restarts, the held word stays
      st_n  = TX_IDLE;
      sh_n  = '0;
      cnt_n = '0;
      bit_n = 1'b0;
      fs_n  = 1'b0;
    end else begin
      case (st_q)
        TX_IDLE: if (tx_valid) begin
          hold_n = tx_data;
          st_n   = TX_WAIT;
        end
        TX_WAIT: if (rise) begin
          fs_n = 1'b1;
          sh_n = hold_q;
          st_n = TX_SYNC;
        end
        TX_SYNC: if (rise) begin
          fs_n  = 1'b0;
          bit_n = sh_q[WORD_W-1];
          sh_n  = {sh_q[WORD_W-2:0], 1'b0};
          cnt_n = CW'(WORD_W - 1);
          st_n  = TX_DATA;
        end
        default: if (rise) begin
          if (cnt_q == '0) begin
            bit_n = 1'b0;
            st_n  = TX_IDLE;
          end else begin
            bit_n = sh_q[WORD_W-1];
            sh_n  = {sh_q[WORD_W-2:0], 1'b0};
            cnt_n = cnt_q - CW'(1);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      hold_q <= '0;
      sh_q   <= '0;
      cnt_q  <= '0;
      bit_q  <= 1'b0;
      fs_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      hold_q <= hold_n;
      sh_q   <= sh_n;
      cnt_q  <= cnt_n;
      bit_q  <= bit_n;
      fs_q   <= fs_n;
    end
  end

  assign bit_out = bit_q;
  assign fs_out  = fs_q;
  assign driving = (st_q == TX_DATA);
endmodule

// File: rtl/fsp_rx.sv
`timescale 1ns/1ps
module fsp_rx
  import fsp_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              fall,
  input  logic              rxd,
  input  logic              rxfs,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid
);
  localparam int CW = $clog2(WORD_W + 1);

  fsp_rx_st_e        st_q, st_n;
  logic [WORD_W-2:0] sh_q, sh_n;
  logic [WORD_W-1:0] data_q, data_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic              vld_q, vld_n;

  always_comb begin
    st_n   = st_q;
    sh_n   = sh_q;
    data_n = data_q;
    cnt_n  = cnt_q;
    vld_n  = 1'b0;
    if (!en) begin
      st_n  = RX_HUNT;
      sh_n  = '0;
      cnt_n = '0;
    end else if (fall) begin
      if (st_q == RX_HUNT) begin
        if (rxfs) begin
          st_n  = RX_BITS;
          cnt_n = CW'(WORD_W);
        end
      end else begin
        sh_n = {sh_q[WORD_W-3:0], rxd};
        if (cnt_q == CW'(1)) begin
          data_n = {sh_q, rxd};
          vld_n  = 1'b1;
          if (rxfs)
            cnt_n = CW'(WORD_W);
          else
            st_n = RX_HUNT;
        end else begin
          cnt_n = cnt_q - CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_HUNT;
      sh_q   <= '0;
      data_q <= '0;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      sh_q   <= sh_n;
      data_q <= data_n;
      cnt_q  <= cnt_n;
      vld_q  <= vld_n;
    end
  end

  assign rx_data  = data_q;
  assign rx_valid = vld_q;
endmodule

// File: rtl/fsport.sv
`timescale 1ns/1ps
module fsport #(
  parameter int WORD_W = 16,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic [DIV_W-1:0]  pre_div,
  input  logic [DIV_W-1:0]  bit_div,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              ser_clk,
  output logic              txd_out,
  output logic              txd_oe,
  output logic              txfs_out,
  output logic              txfs_oe,
  input  logic              rxd_in,
  input  logic              rxfs_in
);
  logic rst_sn, en_s, rise, fall, driving;

  fsp_sync2 u_rsync (.clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sn));
  fsp_sync2 u_esync (.clk(clk), .rst_n(rst_sn), .d(port_en), .q(en_s));

  fsp_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_sn), .en(en_s), .pre_div(pre_div), .bit_div(bit_div),
    .ser_clk(ser_clk), .rise(rise), .fall(fall)
  );

  fsp_tx #(.WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_sn), .en(en_s), .rise(rise), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .bit_out(txd_out),
    .fs_out(txfs_out), .driving(driving)
  );

  fsp_rx #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_sn), .en(en_s), .fall(fall), .rxd(rxd_in),
    .rxfs(rxfs_in), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  assign txd_oe  = en_s && driving;
  assign txfs_oe = en_s;
endmodule

// File: rtl/fsport_chk.sv
`timescale 1ns/1ps
module fsport_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_s,
  input logic              ser_clk,
  input logic              txd_out,
  input logic              txfs_out,
  input logic              txd_oe,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic [WORD_W-1:0] rx_data
);
  // R8
  sclk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> !ser_clk);

  // R2
  tx_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_s && $past(en_s) && (!$stable(txd_out) || !$stable(txfs_out))) |-> $rose(ser_clk));

  // R3
  fs_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txfs_out |-> !txd_oe);

  // R6
  take_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R5
  strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R9
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> rx_valid);
endmodule

bind fsport fsport_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_s(en_s), .ser_clk(ser_clk), .txd_out(txd_out),
  .txfs_out(txfs_out), .txd_oe(txd_oe), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_data(rx_data)
);

// File: tb/sim_fsport.sv
`timescale 1ns/1ps
module sim_fsport;
  localparam int W  = 16;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst_n, port_en, tx_valid, lb, b_sdi, b_fs;
  logic [DW-1:0] pre_div, bit_div;
  logic [W-1:0]  tx_data;
  logic          tx_ready, rx_valid, ser_clk, txd_out, txd_oe, txfs_out, txfs_oe;
  logic [W-1:0]  rx_data;
  logic          rxd_in, rxfs_in;

  always #10 clk = ~clk;

  assign rxd_in  = lb ? txd_out : b_sdi;
  assign rxfs_in = lb ? (txfs_out & txfs_oe) : b_fs;

  fsport #(.WORD_W(W), .DIV_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .pre_div(pre_div), .bit_div(bit_div),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .ser_clk(ser_clk), .txd_out(txd_out), .txd_oe(txd_oe),
    .txfs_out(txfs_out), .txfs_oe(txfs_oe), .rxd_in(rxd_in), .rxfs_in(rxfs_in)
  );

  int checks = 0, fails = 0, epoch = 0, r2_bad = 0, r2_seen = 0;
  logic [W-1:0] exp_ser[$];
  logic [W-1:0] exp_par[$];
  string        par_tag[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: offers a word and records what should come out
  task automatic send(input logic [W-1:0] w, input bit track, input string tag);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data  = w;
    tx_valid = 1'b1;
    if (track) begin
      exp_ser.push_back(w);
      exp_par.push_back(w);
      par_tag.push_back(tag);
    end
    @(negedge clk);
    tx_valid = 1'b0;
    chk(!tx_ready, "R6 ready after take", 32'(tx_ready), 0);
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_ser.size() != 0 || exp_par.size() != 0) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 5000, "R5 drain", 32'(exp_par.size()), 0);
  endtask

  task automatic measure(input int per, input string tag);
    longint t0, t1, t2;
    @(posedge ser_clk);
    @(posedge ser_clk); t0 = $time;
    @(negedge ser_clk); t1 = $time;
    @(posedge ser_clk); t2 = $time;
    chk((t2 - t0) == 64'(per * 20), {tag, " period"}, 32'((t2 - t0) / 20), 32'(per));
    chk((t1 - t0) == 64'((per / 2) * 20), {tag, " high time"}, 32'((t1 - t0) / 20), 32'(per / 2));
  endtask

  // R11 driver: two words, second frame sync on first word's LSB slot
  task automatic drive_rx(input logic [W-1:0] w0, input logic [W-1:0] w1);
    exp_par.push_back(w0); par_tag.push_back("R11 first");
    exp_par.push_back(w1); par_tag.push_back("R11 second");
    @(posedge ser_clk); #1; b_fs = 1'b1; b_sdi = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      @(posedge ser_clk); #1; b_fs = (i == 0); b_sdi = w0[i];
    end
    for (int i = W - 1; i >= 0; i--) begin
      @(posedge ser_clk); #1; b_fs = 1'b0; b_sdi = w1[i];
    end
    @(posedge ser_clk); #1; b_sdi = 1'b0;
  endtask

  // serial monitor (R3, R4)
  initial begin
    forever begin
      int ep;
      logic [W-1:0] got, e;
      bit ok_oe, abort;
      @(negedge ser_clk); #1;
      if (txfs_oe && txfs_out) begin
        ep = epoch; got = '0; ok_oe = 1'b1; abort = 1'b0;
        for (int i = 0; i < W; i++) begin
          @(negedge ser_clk); #1;
          if (epoch != ep) begin abort = 1'b1; break; end
          if (!txd_oe || txfs_out) ok_oe = 1'b0;
          got = {got[W-2:0], txd_out};
        end
        if (!abort) begin
          chk(ok_oe, "R3 oe during bits", 32'(ok_oe), 1);
          @(negedge ser_clk); #1;
          if (epoch == ep) chk(!txd_oe, "R4 oe after word", 32'(txd_oe), 0);
          if (exp_ser.size() == 0) chk(1'b0, "R3 unexpected word", 32'(got), 0);
          else begin
            e = exp_ser.pop_front();
            chk(got == e, "R3 serial word", 32'(got), 32'(e));
          end
        end
      end
    end
  end

  // parallel monitor (R5, R8, R9, R11)
  initial begin
    forever begin
      logic [W-1:0] e;
      string t;
      @(negedge clk);
      if (rx_valid) begin
        if (exp_par.size() == 0) chk(1'b0, "R8 unexpected rx_valid", 32'(rx_data), 0);
        else begin
          e = exp_par.pop_front();
          t = par_tag.pop_front();
          chk(rx_data == e, t, 32'(rx_data), 32'(e));
        end
      end
    end
  end

  // edge-alignment monitor (R2)
  initial begin
    logic p_sdo, p_fs, p_clk, p_oe;
    @(negedge clk);
    p_sdo = txd_out; p_fs = txfs_out; p_clk = ser_clk; p_oe = txfs_oe;
    forever begin
      @(negedge clk);
      if (txfs_oe && p_oe && (txd_out != p_sdo || txfs_out != p_fs)) begin
        r2_seen++;
        if (!(ser_clk && !p_clk)) r2_bad++;
      end
      p_sdo = txd_out; p_fs = txfs_out; p_clk = ser_clk; p_oe = txfs_oe;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit bad_clk, bad_oe, bad_rdy;
    rst_n = 1'b0; port_en = 1'b0; tx_valid = 1'b0; tx_data = '0;
    lb = 1'b1; b_sdi = 1'b0; b_fs = 1'b0;
    pre_div = 4'd2; bit_div = 4'd3;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!ser_clk && !txd_oe && !txfs_oe, "R10 outputs idle after reset", {29'b0, ser_clk, txd_oe, txfs_oe}, 0);
    chk(!tx_ready && !rx_valid, "R8 no ready while off", {30'b0, tx_ready, rx_valid}, 0);
    chk(rx_data == '0, "R10 rx_data after reset", 32'(rx_data), 0);

    port_en = 1'b1;
    repeat (5) @(negedge clk);
    chk(tx_ready && txfs_oe, "R6 ready when enabled", {30'b0, tx_ready, txfs_oe}, 3);
    measure(6, "R1 2x3");
    chk(!txd_oe, "R4 idle oe low", 32'(txd_oe), 0);

    send(16'hA5C3, 1'b1, "R5 loopback A5C3");
    drain();
    send(16'h8001, 1'b1, "R5 loopback 8001");
    send(16'h7FFE, 1'b1, "R5 loopback 7FFE");
    drain();

    @(negedge clk); pre_div = 4'd0; bit_div = 4'd0;
    measure(2, "R7 zero dividers");
    send(16'hFFFF, 1'b1, "R7 loopback fast FFFF");
    send(16'h0000, 1'b1, "R7 loopback fast 0000");
    drain();

    @(negedge clk); pre_div = 4'd3; bit_div = 4'd1;
    measure(3, "R1 3x1 odd");
    send(16'h6B2D, 1'b1, "R5 loopback odd 6B2D");
    drain();
    @(negedge clk); pre_div = 4'd1; bit_div = 4'd1;
    measure(2, "R7 1x1 clamp");

    @(negedge clk); pre_div = 4'd2; bit_div = 4'd2;
    lb = 1'b0;
    drive_rx(16'h1234, 16'hBEEF);
    drain();
    chk(rx_data == 16'hBEEF, "R11 last word held", 32'(rx_data), 32'hBEEF);

    // disable in the middle of a word
    lb = 1'b1;
    send(16'h5555, 1'b0, "");
    repeat (40) @(negedge clk);
    port_en = 1'b0;
    epoch++;
    repeat (4) @(negedge clk);
    lb = 1'b0;
    bad_clk = 1'b0; bad_oe = 1'b0; bad_rdy = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      b_fs = i[2]; b_sdi = i[0];
      if (ser_clk) bad_clk = 1'b1;
      if (txd_oe || txfs_oe) bad_oe = 1'b1;
      if (tx_ready) bad_rdy = 1'b1;
    end
    chk(!bad_clk, "R8 clock stopped", 32'(bad_clk), 0);
    chk(!bad_oe, "R8 pads released", 32'(bad_oe), 0);
    chk(!bad_rdy, "R8 ready low", 32'(bad_rdy), 0);
    b_fs = 1'b0; b_sdi = 1'b0;
    port_en = 1'b1;
    repeat (5) @(negedge clk);
    chk(rx_data == 16'hBEEF, "R9 rx_data kept", 32'(rx_data), 32'hBEEF);
    chk(tx_ready, "R9 ready after re-enable", 32'(tx_ready), 1);
    lb = 1'b1;
    send(16'h3C96, 1'b1, "R9 loopback after re-enable");
    drain();

    chk(r2_bad == 0 && r2_seen > 0, "R2 changes on rising edge", 32'(r2_bad), 0);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(rx_data == '0 && !txd_oe && !ser_clk, "R10 reset clears", 32'(rx_data), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule